// File: doc/BRIEF.md
# Exception Escalation Controller

This block stands between the exception sources of a small processor core and its handler dispatch logic. Each incoming exception arrives as a vector number with a fault-or-trap flag, an optional error code and a marker saying whether the excepting instruction redirected control flow. The block sorts the vector into one of three severity classes (benign, contributory, page fault). It also remembers whether a handler invocation is still in progress.

When a second exception arrives while an invocation is open, a class-pair matrix decides the outcome. The second exception is either dispatched in turn, or the pair is replaced by a double fault on vector 8 with a zero error code. Any exception taken while the double-fault invocation is still open sends the block into a shutdown state, which only reset clears. For each dispatch the block reports the vector, the error code, whether an error code applies, and which instruction pointer the handler entry should save.

Top module: `exc_escalator`

## Requirements
- R1: Vectors 0, 9, 10, 11, 12 and 13 are contributory. Vector 14 is the page-fault class. Every other vector, including 1-7, 16 and unlisted numbers such as 200, is benign.
- R2: An exception accepted while idle is dispatched exactly one cycle later (`disp_valid` high for one cycle). It carries the same vector, error code and has-code flag.
- R3: A contributory exception accepted while a contributory invocation is open dispatches vector 8 with `disp_code` = 0, `disp_has_code` = 1 and `disp_ptr_sel` = 3.
- R4: If the open invocation is benign, any second exception is dispatched unchanged. If it is contributory and the second is a page fault, the page fault is dispatched unchanged. Each such dispatch becomes the new open invocation, with its own class.
- R5: A contributory or page-fault exception accepted while a page-fault invocation is open dispatches the double fault exactly as in R3.
- R6: An exception accepted while the double-fault invocation is open produces no dispatch. The next cycle `shutdown` = 1 and `exc_ready` = 0. This state survives `inv_done` and is left only by reset.
- R7: `disp_ptr_sel` is 0 (faulting instruction) for a fault, 1 (next instruction) for a trap, and 2 (branch target) for a trap whose `exc_redirect` is set.
- R8: A one-cycle `inv_done` closes the open invocation, or the double-fault invocation, and returns the block to idle.
- R9: `exc_ready` is high in every state except shutdown. Nothing is dispatched without an accepted exception one cycle earlier.
- R10: When `inv_done` and an accepted exception coincide, the exception is handled as if the block were already idle.
- R11: After reset `disp_valid` = 0, `shutdown` = 0 and `exc_ready` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_valid | input | 1 | Exception offered |
| exc_ready | output | 1 | Exception can be accepted |
| exc_vector | input | VEC_W (8) | Vector number |
| exc_is_trap | input | 1 | 1 = trap, 0 = fault |
| exc_redirect | input | 1 | Trapping instruction changed control flow |
| exc_code | input | ERR_W (32) | Error code value |
| exc_has_code | input | 1 | Error code applies |
| inv_done | input | 1 | Handler invocation finished |
| disp_valid | output | 1 | Dispatch pulse |
| disp_vector | output | VEC_W (8) | Vector to dispatch |
| disp_code | output | ERR_W (32) | Error code to supply |
| disp_has_code | output | 1 | Error code applies |
| disp_ptr_sel | output | 2 | Pointer to save: 0 faulting, 1 next, 2 target, 3 none |
| shutdown | output | 1 | Shutdown state |

## Verification
A wrong invocation class shows on the second exception. A pair that should be dispatched comes out as vector 8, or a double fault shows its own vector, one cycle after that second acceptance. A state that missed `inv_done` or the double fault gives the wrong dispatch on the next exception, or it fails to raise `shutdown` in the cycle after it. The scoreboard keeps its own class and state model, so any such divergence appears as a mismatch or an unexpected pulse one cycle after the exception that exposed it.

// File: rtl/excesc_pkg.sv
package excesc_pkg;
   typedef enum logic [1:0] {
      CLS_BENIGN  = 2'd0,
      CLS_CONTRIB = 2'd1,
      CLS_PAGE    = 2'd2
   } exc_cls_e;

   typedef enum logic [1:0] {
      PTR_FAULT  = 2'd0,
      PTR_NEXT   = 2'd1,
      PTR_TARGET = 2'd2,
      PTR_NONE   = 2'd3
   } ptr_sel_e;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_INVOKE = 2'd1,
      ST_DOUBLE = 2'd2,
      ST_HALT   = 2'd3
   } esc_state_e;
endpackage

// File: rtl/exc_classifier.sv
module exc_classifier
   import excesc_pkg::*;
#(
   parameter int          VEC_W        = 8,
   parameter logic [31:0] CONTRIB_MASK = 32'h0000_3E01,
   parameter logic [31:0] PAGE_MASK    = 32'h0000_4000
) (
   input  logic [VEC_W-1:0] vec,
   output exc_cls_e         cls
);
   localparam int LOW_W = 5;

   generate
      if (VEC_W < LOW_W) begin : g_bad_width
         $error("exc_classifier: VEC_W must be at least 5");
      end
      if ((CONTRIB_MASK & PAGE_MASK) != 32'h0) begin : g_bad_mask
         $error("exc_classifier: class masks overlap");
      end
   endgenerate

   logic             above;
   logic [LOW_W-1:0] idx;

   assign idx = vec[LOW_W-1:0];

   generate
      if (VEC_W > LOW_W) begin : g_wide
         assign above = |vec[VEC_W-1:LOW_W];
      end else begin : g_narrow
         assign above = 1'b0;
      end
   endgenerate

   always_comb begin
      if (above)                   cls = CLS_BENIGN;
      else if (CONTRIB_MASK[idx])  cls = CLS_CONTRIB;
      else if (PAGE_MASK[idx])     cls = CLS_PAGE;
      else                         cls = CLS_BENIGN;
   end
endmodule

// File: rtl/exc_pair_matrix.sv
module exc_pair_matrix
   import excesc_pkg::*;
(
   input  exc_cls_e open_cls,
   input  exc_cls_e new_cls,
   output logic     escalate
);
   always_comb begin
      unique case (open_cls)
         CLS_CONTRIB: escalate = (new_cls == CLS_CONTRIB);
         CLS_PAGE:    escalate = (new_cls == CLS_CONTRIB) || (new_cls == CLS_PAGE);
         default:     escalate = 1'b0;
      endcase
   end
endmodule

// File: rtl/exc_dispatch_reg.sv
module exc_dispatch_reg #(
   parameter int VEC_W = 8,
   parameter int ERR_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [VEC_W-1:0] vec_d,
   input  logic [ERR_W-1:0] code_d,
   input  logic             has_d,
   input  logic [1:0]       sel_d,
   output logic             valid_q,
   output logic [VEC_W-1:0] vec_q,
   output logic [ERR_W-1:0] code_q,
   output logic             has_q,
   output logic [1:0]       sel_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         vec_q   <= '0;
         code_q  <= '0;
         has_q   <= 1'b0;
         sel_q   <= 2'd0;
      end else begin
         valid_q <= load;
         if (load) begin
            vec_q  <= vec_d;
            code_q <= code_d;
            has_q  <= has_d;
            sel_q  <= sel_d;
         end
      end
   end
endmodule

// File: rtl/exc_escalator.sv
module exc_escalator
   import excesc_pkg::*;
#(
   parameter int          VEC_W        = 8,
   parameter int          ERR_W        = 32,
   parameter int          DF_VECTOR    = 8,
   parameter logic [31:0] CONTRIB_MASK = 32'h0000_3E01,
   parameter logic [31:0] PAGE_MASK    = 32'h0000_4000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             exc_valid,
   output logic             exc_ready,
   input  logic [VEC_W-1:0] exc_vector,
   input  logic             exc_is_trap,
   input  logic             exc_redirect,
   input  logic [ERR_W-1:0] exc_code,
   input  logic             exc_has_code,
   input  logic             inv_done,
   output logic             disp_valid,
   output logic [VEC_W-1:0] disp_vector,
   output logic [ERR_W-1:0] disp_code,
   output logic             disp_has_code,
   output logic [1:0]       disp_ptr_sel,
   output logic             shutdown
);
   localparam logic [VEC_W-1:0] DF_VEC = VEC_W'(DF_VECTOR);

   generate
      if (ERR_W < 1) begin : g_bad_err
         $error("exc_escalator: ERR_W must be positive");
      end
      if (DF_VECTOR >= (1 << VEC_W)) begin : g_bad_df
         $error("exc_escalator: DF_VECTOR does not fit in VEC_W");
      end
   endgenerate

   esc_state_e state_q, state_d, base_state;
   exc_cls_e   open_q, open_d, new_cls;
   logic       accept, escalate;
   logic       load;
   logic [VEC_W-1:0] vec_d;
   logic [ERR_W-1:0] code_d;
   logic             has_d;
   ptr_sel_e         sel_d, own_sel;

   exc_classifier #(
      .VEC_W(VEC_W), .CONTRIB_MASK(CONTRIB_MASK), .PAGE_MASK(PAGE_MASK)
   ) u_class (
      .vec(exc_vector), .cls(new_cls)
   );

   exc_pair_matrix u_matrix (
      .open_cls(open_q), .new_cls(new_cls), .escalate(escalate)
   );

   assign exc_ready = (state_q != ST_HALT);
   assign accept    = exc_valid && exc_ready;

   always_comb begin
      if (!exc_is_trap)      own_sel = PTR_FAULT;
      else if (exc_redirect) own_sel = PTR_TARGET;
      else                   own_sel = PTR_NEXT;
   end

   always_comb begin
      base_state = state_q;
      if (inv_done && (state_q == ST_INVOKE || state_q == ST_DOUBLE))
         base_state = ST_IDLE;
   end

   always_comb begin
      state_d = base_state;
      open_d  = open_q;
      load    = 1'b0;
      vec_d   = exc_vector;
      code_d  = exc_code;
      has_d   = exc_has_code;
      sel_d   = own_sel;
      if (accept) begin
         unique case (base_state)
            ST_IDLE: begin
               load    = 1'b1;
               state_d = ST_INVOKE;
               open_d  = new_cls;
            end
            ST_INVOKE: begin
               load = 1'b1;
               if (escalate) begin
                  vec_d   = DF_VEC;
                  code_d  = '0;
                  has_d   = 1'b1;
                  sel_d   = PTR_NONE;
                  state_d = ST_DOUBLE;
               end else begin
                  state_d = ST_INVOKE;
                  open_d  = new_cls;
               end
            end
            ST_DOUBLE: state_d = ST_HALT;
            default:   state_d = ST_HALT;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         open_q  <= CLS_BENIGN;
      end else begin
         state_q <= state_d;
         open_q  <= open_d;
      end
   end

   exc_dispatch_reg #(.VEC_W(VEC_W), .ERR_W(ERR_W)) u_disp (
      .clk(clk), .rst_n(rst_n), .load(load),
      .vec_d(vec_d), .code_d(code_d), .has_d(has_d), .sel_d(sel_d),
      .valid_q(disp_valid), .vec_q(disp_vector), .code_q(disp_code),
      .has_q(disp_has_code), .sel_q(disp_ptr_sel)
   );

   assign shutdown = (state_q == ST_HALT);
endmodule

// File: rtl/exc_escalator_chk.sv
module exc_escalator_chk #(
   parameter int VEC_W     = 8,
   parameter int ERR_W     = 32,
   parameter int DF_VECTOR = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             exc_valid,
   input logic             exc_ready,
   input logic [VEC_W-1:0] exc_vector,
   input logic             exc_is_trap,
   input logic             exc_redirect,
   input logic             disp_valid,
   input logic [VEC_W-1:0] disp_vector,
   input logic [ERR_W-1:0] disp_code,
   input logic             disp_has_code,
   input logic [1:0]       disp_ptr_sel,
   input logic             shutdown
);
   // R3 / R5: a double-fault dispatch carries a zero error code
   a_r3_df_zero_code: assert property (@(posedge clk) disable iff (!rst_n)
      (disp_valid && disp_ptr_sel == 2'd3) |->
         (disp_vector == VEC_W'(DF_VECTOR) && disp_code == '0 && disp_has_code));

   // R6: shutdown is sticky
   a_r6_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      shutdown |=> shutdown);

   // R6: nothing accepted or dispatched in shutdown
   a_r6_halt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      shutdown |-> (!exc_ready && !disp_valid));

   // R9: ready whenever not in shutdown
   a_r9_ready_live: assert property (@(posedge clk) disable iff (!rst_n)
      !shutdown |-> exc_ready);

   // R9 / R2: every dispatch follows an acceptance
   a_r2_dispatch_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
      disp_valid |-> $past(exc_valid && exc_ready));

   // R2 / R4: a non-escalated dispatch keeps the accepted vector
   a_r4_vector_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (disp_valid && disp_ptr_sel != 2'd3) |-> (disp_vector == $past(exc_vector)));

   // R7: pointer select follows the fault/trap flags
   a_r7_ptr_sel: assert property (@(posedge clk) disable iff (!rst_n)
      (disp_valid && disp_ptr_sel != 2'd3) |->
         (disp_ptr_sel == ($past(exc_is_trap) ? ($past(exc_redirect) ? 2'd2 : 2'd1) : 2'd0)));
endmodule

bind exc_escalator exc_escalator_chk #(
   .VEC_W(VEC_W), .ERR_W(ERR_W), .DF_VECTOR(DF_VECTOR)
) u_chk (
   .clk(clk), .rst_n(rst_n), .exc_valid(exc_valid), .exc_ready(exc_ready),
   .exc_vector(exc_vector), .exc_is_trap(exc_is_trap), .exc_redirect(exc_redirect),
   .disp_valid(disp_valid), .disp_vector(disp_vector), .disp_code(disp_code),
   .disp_has_code(disp_has_code), .disp_ptr_sel(disp_ptr_sel), .shutdown(shutdown)
);

// File: tb/tb_exc_escalator.sv
`timescale 1ns/1ps
module tb_exc_escalator;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        exc_valid = 1'b0;
   logic        exc_ready;
   logic [7:0]  exc_vector = '0;
   logic        exc_is_trap = 1'b0;
   logic        exc_redirect = 1'b0;
   logic [31:0] exc_code = '0;
   logic        exc_has_code = 1'b0;
   logic        inv_done = 1'b0;
   logic        disp_valid;
   logic [7:0]  disp_vector;
   logic [31:0] disp_code;
   logic        disp_has_code;
   logic [1:0]  disp_ptr_sel;
   logic        shutdown;

   always #2 clk = ~clk;

   exc_escalator dut (
      .clk(clk), .rst_n(rst_n), .exc_valid(exc_valid), .exc_ready(exc_ready),
      .exc_vector(exc_vector), .exc_is_trap(exc_is_trap), .exc_redirect(exc_redirect),
      .exc_code(exc_code), .exc_has_code(exc_has_code), .inv_done(inv_done),
      .disp_valid(disp_valid), .disp_vector(disp_vector), .disp_code(disp_code),
      .disp_has_code(disp_has_code), .disp_ptr_sel(disp_ptr_sel), .shutdown(shutdown)
   );

   typedef struct packed {
      logic [7:0]  v;
      logic [31:0] c;
      logic        h;
      logic [1:0]  s;
   } item_t;

   item_t sb[$];
   string tags[$];
   int checks = 0;
   int errors = 0;
   int m_state = 0;   // 0 idle, 1 invoke, 2 double, 3 shutdown
   int m_cls = 0;     // 0 benign, 1 contributory, 2 page

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic int cls_of(input logic [7:0] v);
      if (v == 0 || (v >= 9 && v <= 13)) return 1;
      if (v == 14) return 2;
      return 0;
   endfunction

   // monitor
   always @(negedge clk) begin
      if (rst_n && disp_valid) begin
         if (sb.size() == 0) begin
            chk(1'b0, "R9 unexpected dispatch", disp_vector, 0);
         end else begin
            item_t e;
            string t;
            e = sb.pop_front();
            t = tags.pop_front();
            chk(disp_vector == e.v, {t, " vector"}, disp_vector, e.v);
            chk(disp_code == e.c, {t, " code"}, disp_code, e.c);
            chk(disp_has_code == e.h, {t, " has_code"}, disp_has_code, e.h);
            chk(disp_ptr_sel == e.s, {t, " ptr_sel"}, disp_ptr_sel, e.s);
         end
      end
   end

   task automatic send(input logic [7:0] v, input bit trap, input bit redir,
                       input logic [31:0] code, input bit has, input bit with_done,
                       input string tag);
      int c;
      item_t e;
      c = cls_of(v);
      if (with_done && (m_state == 1 || m_state == 2)) m_state = 0;
      e.v = v; e.c = code; e.h = has;
      e.s = trap ? (redir ? 2'd2 : 2'd1) : 2'd0;
      if (m_state == 0) begin
         sb.push_back(e); tags.push_back(tag); m_state = 1; m_cls = c;
      end else if (m_state == 1) begin
         if ((m_cls == 1 && c == 1) || (m_cls == 2 && (c == 1 || c == 2))) begin
            e.v = 8'd8; e.c = 0; e.h = 1'b1; e.s = 2'd3;
            m_state = 2;
         end else begin
            m_cls = c;
         end
         sb.push_back(e); tags.push_back(tag);
      end else if (m_state == 2) begin
         m_state = 3;
      end
      @(negedge clk);
      exc_valid = 1'b1; exc_vector = v; exc_is_trap = trap; exc_redirect = redir;
      exc_code = code; exc_has_code = has; inv_done = with_done;
      @(negedge clk);
      exc_valid = 1'b0; inv_done = 1'b0;
   endtask

   task automatic done_pulse();
      if (m_state == 1 || m_state == 2) m_state = 0;
      @(negedge clk); inv_done = 1'b1;
      @(negedge clk); inv_done = 1'b0;
   endtask

   task automatic drain(input string tag);
      @(negedge clk); @(negedge clk);
      chk(sb.size() == 0, tag, sb.size(), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      chk(disp_valid == 1'b0, "R11 disp_valid", disp_valid, 0);
      chk(shutdown == 1'b0, "R11 shutdown", shutdown, 0);
      chk(exc_ready == 1'b1, "R11 exc_ready", exc_ready, 1);

      // R2 / R7: idle dispatch, fault pointer
      send(8'd13, 0, 0, 32'hABCD, 1, 0, "R2 R7 first fault");
      // R3: contributory after contributory -> double fault
      send(8'd11, 0, 0, 32'h18, 1, 0, "R3 contrib pair");
      done_pulse();  // R8 leaves double-fault invocation
      drain("R8 queue after double fault");

      // R1 / R4: unlisted vector is benign, then serial dispatch
      send(8'd200, 1, 0, 0, 0, 0, "R1 R7 unlisted trap next");
      send(8'd13, 1, 1, 32'h5, 1, 0, "R4 R7 benign then contrib target");
      send(8'd12, 0, 0, 32'h7, 1, 0, "R1 R3 contrib escalates after serial");
      done_pulse();

      // R4: contributory then page fault is serial; page then page doubles (R5)
      send(8'd10, 0, 0, 32'h21, 1, 0, "R4 contrib first");
      send(8'd14, 0, 0, 32'h2, 1, 0, "R4 page after contrib serial");
      send(8'd14, 0, 0, 32'h3, 1, 0, "R5 page after page");
      done_pulse();

      // R5: page then contributory
      send(8'd14, 0, 0, 32'h4, 1, 0, "R5 page first");
      send(8'd0, 0, 0, 0, 0, 0, "R5 contrib after page");
      done_pulse();

      // R4: benign first then page and benign pairs
      send(8'd16, 1, 0, 0, 0, 0, "R4 benign first");
      send(8'd14, 0, 0, 32'h9, 1, 0, "R4 page after benign");
      done_pulse();
      send(8'd3, 1, 0, 0, 0, 0, "R4 breakpoint first");
      send(8'd6, 0, 0, 0, 0, 0, "R4 benign after benign");
      done_pulse();

      // R8: done closes contributory invocation, new contrib is a first exception
      send(8'd13, 0, 0, 32'h1, 1, 0, "R8 contrib before done");
      done_pulse();
      send(8'd12, 0, 0, 32'h2, 1, 0, "R8 contrib after done");
      // R10: done coinciding with accept
      send(8'd11, 0, 0, 32'h3, 1, 1, "R10 done with accept");
      drain("R10 queue empty");

      // R6: shutdown
      send(8'd11, 0, 0, 32'h3, 1, 0, "R6 setup double fault");
      send(8'd1, 1, 0, 0, 0, 0, "R6 into shutdown");
      chk(shutdown == 1'b1, "R6 shutdown set", shutdown, 1);
      chk(exc_ready == 1'b0, "R6 ready low", exc_ready, 0);
      exc_valid = 1'b1; exc_vector = 8'd13;
      repeat (3) @(negedge clk);
      exc_valid = 1'b0;
      @(negedge clk); inv_done = 1'b1;
      @(negedge clk); inv_done = 1'b0;
      @(negedge clk);
      chk(shutdown == 1'b1, "R6 shutdown survives done", shutdown, 1);
      chk(exc_ready == 1'b0, "R6 ready stays low", exc_ready, 0);
      chk(sb.size() == 0, "R6 no dispatch in shutdown", sb.size(), 0);

      rst_n = 1'b0; m_state = 0;
      @(negedge clk); @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(shutdown == 1'b0, "R6 reset clears shutdown", shutdown, 0);
      chk(exc_ready == 1'b1, "R11 ready after reset", exc_ready, 1);
      send(8'd13, 0, 0, 32'h77, 1, 0, "R2 dispatch after reset");
      drain("R2 final queue empty");

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(4ns * 20000);
      checks++;
      errors++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule